// File: doc/BRIEF.md
# Rate-Adapting Packet Buffer with Parity Gap Insertion

This block sits between a byte-wide transport input and a downstream stage that adds Reed-Solomon parity. Packets arrive on the input clock with idle cycles of any length between them, zero included. Each packet is 188 bytes long and opens with the sync value 0x47. The block holds the bytes in a 128-entry circular store. It replays them on an independent output clock as a fixed frame of 204 byte slots: 188 payload slots followed by 16 empty slots, which the parity stage fills later.

The output side stays idle until the store is half full. This leaves roughly equal slack for an input that runs fast and for one that runs slow, so a drift of more than 56 bytes either way can be absorbed. Read and write positions cross between the clock domains as Gray codes through two-flop synchronisers. An overrun flag and an underrun flag record the two failure modes. Each flag stays set until a clear pulse arrives in its own clock domain. The number of stored bytes is reported on the input side.

Top module: `pkt_gap_buffer`

## Requirements
- R1: After reset, out_valid, out_sop, out_data, fill_level, overrun and underrun are all zero.
- R2: When a packet is due to start (input byte count at zero), an incoming byte other than 0x47 is discarded. It is not stored and does not advance the count.
- R3: Accepted bytes leave in arrival order, whatever idle gaps separate the input packets, including none.
- R4: Each output frame is 204 slots long: 188 payload slots, then 16 slots in which out_valid is low and out_data is zero.
- R5: out_sop is high together with the first byte of every packet (payload slot 0) and low in every other cycle.
- R6: After reset or after an underrun, no byte is output until the output side sees at least 64 stored bytes.
- R7: fill_level equals the number of bytes stored as seen from the input side, from 0 up to 128.
- R8: A byte that arrives while the store holds 128 bytes is dropped, and overrun sets and stays set. Under a bounded rate drift, overrun stays low.
- R9: If a payload slot comes due with the store empty, underrun sets and stays set, no byte is output, and the output side returns to waiting for 64 bytes.
- R10: A pulse on in_flag_clr clears overrun, and a pulse on out_flag_clr clears underrun. A clear takes priority over a setting event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Input byte clock |
| in_rst_n | input | 1 | Synchronous active-low reset, input domain |
| in_valid | input | 1 | in_data carries a byte this cycle |
| in_data | input | 8 | Input byte |
| in_flag_clr | input | 1 | Clears overrun (input domain) |
| fill_level | output | 8 | Bytes held in the store, input-side view |
| overrun | output | 1 | Sticky: a write hit a full store |
| out_clk | input | 1 | Output slot clock |
| out_rst_n | input | 1 | Synchronous active-low reset, output domain |
| out_flag_clr | input | 1 | Clears underrun (output domain) |
| out_valid | output | 1 | out_data carries a payload byte |
| out_data | output | 8 | Output byte, zero in idle slots |
| out_sop | output | 1 | First byte of a packet |
| underrun | output | 1 | Sticky: a payload slot found the store empty |

## Verification
The checker assumes that each clear pulse is synchronous to the clock of the flag it clears. It also assumes each reset is held for several cycles of its own clock, and it judges each property only in the domain that drives the signals involved. The stimulus drives inputs on the falling edge of each clock. It sends whole 188-byte packets whose average spacing matches the slightly slower output clock, so the fill level stays well inside the 56-byte drift margin during streaming. Overrun is forced only while the output side is held in reset, and underrun only after the input stops, so that both flag checks happen at known points.

// File: rtl/pgb_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the packet gap buffer.
// Assumes pointer widths never exceed GRAY_W bits.
package pgb_pkg;

    localparam int GRAY_W = 16;

    typedef enum logic {
        RD_WAIT = 1'b0,
        RD_RUN  = 1'b1
    } rd_state_e;

    // Binary to reflected Gray code.
    function automatic logic [GRAY_W-1:0] bin_to_gray(input logic [GRAY_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary.
    function automatic logic [GRAY_W-1:0] gray_to_bin(input logic [GRAY_W-1:0] g);
        logic [GRAY_W-1:0] b;
        b[GRAY_W-1] = g[GRAY_W-1];
        for (int i = GRAY_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/pgb_ptr_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser for a Gray-coded pointer.
// Assumes the source changes by at most one bit per source clock.
module pgb_ptr_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] gray_out
);
    logic [W-1:0] meta_q;

    // Two-stage capture of the foreign-domain pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            gray_out <= '0;
        end else begin
            meta_q   <= gray_in;
            gray_out <= meta_q;
        end
    end
endmodule

// File: rtl/pgb_store.sv
`timescale 1ns/1ps
// Circular byte store: one write port on the input clock and an
// asynchronous read port that the output side samples into registers.
// Assumes the caller never writes the slot being read.
module pgb_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int ENTRIES = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [ENTRIES];

    // Store a byte on each accepted write.
    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pgb_writer.sv
`timescale 1ns/1ps
// Input-side control. It hunts for the sync byte at packet
// boundaries, accepts bytes while space remains, and keeps the write
// pointer, the fill count and the sticky overrun flag.
// Assumes rd_gray_sync has already been synchronised to in_clk.
module pgb_writer #(
    parameter int          DATA_W    = 8,
    parameter int          DEPTH     = 128,
    parameter int          PKT_LEN   = 188,
    parameter logic [7:0]  SYNC_BYTE = 8'h47,
    parameter int          ADDR_W    = 7,
    parameter int          PTR_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              flag_clr,
    input  logic [PTR_W-1:0]  rd_gray_sync,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [PTR_W-1:0]  wr_gray,
    output logic [PTR_W-1:0]  fill,
    output logic              overrun
);
    import pgb_pkg::*;

    localparam int IDX_W = $clog2(PKT_LEN);

    logic [PTR_W-1:0] wr_bin;
    logic [PTR_W-1:0] rd_bin;
    logic [PTR_W-1:0] wr_next;
    logic [IDX_W-1:0] pkt_idx;
    logic             hunting;
    logic             counted;
    logic             full;

    // Decode space, sync hunting and the accept decision.
    always_comb begin
        rd_bin  = PTR_W'(gray_to_bin(GRAY_W'(rd_gray_sync)));
        fill    = wr_bin - rd_bin;
        full    = (fill == PTR_W'(DEPTH));
        hunting = (pkt_idx == '0) && (in_data[7:0] != SYNC_BYTE);
        counted = in_valid && !hunting;
        wr_en   = counted && !full;
        wr_next = wr_bin + PTR_W'(1);
    end

    assign wr_addr = wr_bin[ADDR_W-1:0];
    assign wr_data = in_data;

    // Advance the write pointer and its Gray copy on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bin  <= '0;
            wr_gray <= '0;
        end else if (wr_en) begin
            wr_bin  <= wr_next;
            wr_gray <= PTR_W'(bin_to_gray(GRAY_W'(wr_next)));
        end
    end

    // Track the byte position within the packet, dropped bytes included.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_idx <= '0;
        end else if (counted) begin
            pkt_idx <= (pkt_idx == IDX_W'(PKT_LEN - 1)) ? '0 : pkt_idx + IDX_W'(1);
        end
    end

    // Sticky overrun flag; a clear wins over a new event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (flag_clr) begin
            overrun <= 1'b0;
        end else if (counted && full) begin
            overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/pgb_reader.sv
`timescale 1ns/1ps
// Output-side framer. It waits for the start threshold, then steps
// through frames of PKT_LEN payload slots and PAR_LEN idle slots.
// It reads one byte per payload slot and drops back to waiting on an
// underrun. Assumes wr_gray_sync has been synchronised to out_clk.
module pgb_reader #(
    parameter int DATA_W     = 8,
    parameter int PKT_LEN    = 188,
    parameter int PAR_LEN    = 16,
    parameter int START_FILL = 64,
    parameter int ADDR_W     = 7,
    parameter int PTR_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_clr,
    input  logic [PTR_W-1:0]  wr_gray_sync,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [PTR_W-1:0]  rd_gray,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              underrun
);
    import pgb_pkg::*;

    localparam int FRAME_LEN = PKT_LEN + PAR_LEN;
    localparam int SLOT_W    = $clog2(FRAME_LEN);

    rd_state_e        state;
    logic [SLOT_W-1:0] slot;
    logic [PTR_W-1:0]  rd_bin;
    logic [PTR_W-1:0]  wr_bin;
    logic [PTR_W-1:0]  avail;
    logic [PTR_W-1:0]  rd_next;
    logic              payload_slot;
    logic              starve;
    logic              take;

    // Decode occupancy and what the current slot needs.
    always_comb begin
        wr_bin       = PTR_W'(gray_to_bin(GRAY_W'(wr_gray_sync)));
        avail        = wr_bin - rd_bin;
        payload_slot = (slot < SLOT_W'(PKT_LEN));
        starve       = (state == RD_RUN) && payload_slot && (avail == '0);
        take         = (state == RD_RUN) && payload_slot && (avail != '0);
        rd_next      = rd_bin + PTR_W'(1);
    end

    assign rd_addr = rd_bin[ADDR_W-1:0];

    // Sequence the wait/run states and the slot counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RD_WAIT;
            slot  <= '0;
        end else if (state == RD_WAIT) begin
            slot <= '0;
            if (avail >= PTR_W'(START_FILL)) begin
                state <= RD_RUN;
            end
        end else if (starve) begin
            state <= RD_WAIT;
            slot  <= '0;
        end else begin
            slot <= (slot == SLOT_W'(FRAME_LEN - 1)) ? '0 : slot + SLOT_W'(1);
        end
    end

    // Advance the read pointer and its Gray copy on each byte taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bin  <= '0;
            rd_gray <= '0;
        end else if (take) begin
            rd_bin  <= rd_next;
            rd_gray <= PTR_W'(bin_to_gray(GRAY_W'(rd_next)));
        end
    end

    // Register the output byte, valid and start-of-packet strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
        end else begin
            out_valid <= take;
            out_data  <= take ? rd_data : '0;
            out_sop   <= take && (slot == '0);
        end
    end

    // Sticky underrun flag; a clear wins over a new event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underrun <= 1'b0;
        end else if (flag_clr) begin
            underrun <= 1'b0;
        end else if (starve) begin
            underrun <= 1'b1;
        end
    end
endmodule

// File: rtl/pkt_gap_buffer.sv
`timescale 1ns/1ps
// Top level: a dual-clock circular store between gapped packet input
// and a framed output that leaves parity gaps. Assumes the two clocks
// are unrelated and that each reset is held for several of its cycles.
module pkt_gap_buffer #(
    parameter int         DATA_W     = 8,
    parameter int         DEPTH      = 128,
    parameter int         PKT_LEN    = 188,
    parameter int         PAR_LEN    = 16,
    parameter int         START_FILL = DEPTH / 2,
    parameter logic [7:0] SYNC_BYTE  = 8'h47,
    localparam int        ADDR_W     = $clog2(DEPTH),
    localparam int        PTR_W      = ADDR_W + 1
) (
    input  logic              in_clk,
    input  logic              in_rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_flag_clr,
    output logic [PTR_W-1:0]  fill_level,
    output logic              overrun,
    input  logic              out_clk,
    input  logic              out_rst_n,
    input  logic              out_flag_clr,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              underrun
);
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [PTR_W-1:0]  wr_gray;
    logic [PTR_W-1:0]  rd_gray;
    logic [PTR_W-1:0]  wr_gray_out;
    logic [PTR_W-1:0]  rd_gray_in;

    pgb_writer #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .PKT_LEN(PKT_LEN),
        .SYNC_BYTE(SYNC_BYTE), .ADDR_W(ADDR_W), .PTR_W(PTR_W)
    ) u_writer (
        .clk(in_clk), .rst_n(in_rst_n), .in_valid(in_valid), .in_data(in_data),
        .flag_clr(in_flag_clr), .rd_gray_sync(rd_gray_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_gray(wr_gray),
        .fill(fill_level), .overrun(overrun)
    );

    pgb_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .wr_clk(in_clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    pgb_ptr_sync #(.W(PTR_W)) u_wr_to_rd (
        .clk(out_clk), .rst_n(out_rst_n), .gray_in(wr_gray), .gray_out(wr_gray_out)
    );

    pgb_ptr_sync #(.W(PTR_W)) u_rd_to_wr (
        .clk(in_clk), .rst_n(in_rst_n), .gray_in(rd_gray), .gray_out(rd_gray_in)
    );

    pgb_reader #(
        .DATA_W(DATA_W), .PKT_LEN(PKT_LEN), .PAR_LEN(PAR_LEN),
        .START_FILL(START_FILL), .ADDR_W(ADDR_W), .PTR_W(PTR_W)
    ) u_reader (
        .clk(out_clk), .rst_n(out_rst_n), .flag_clr(out_flag_clr),
        .wr_gray_sync(wr_gray_out), .rd_data(rd_data), .rd_addr(rd_addr),
        .rd_gray(rd_gray), .out_valid(out_valid), .out_data(out_data),
        .out_sop(out_sop), .underrun(underrun)
    );
endmodule

// File: rtl/pgb_checker.sv
`timescale 1ns/1ps
// Port-level properties of pkt_gap_buffer, each checked in the clock
// domain that drives the signals involved. Attached by bind below.
module pgb_checker #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128,
    parameter int PTR_W  = 8
) (
    input logic              in_clk,
    input logic              in_rst_n,
    input logic              in_flag_clr,
    input logic [PTR_W-1:0]  fill_level,
    input logic              overrun,
    input logic              out_clk,
    input logic              out_rst_n,
    input logic              out_flag_clr,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_sop,
    input logic              underrun
);
    AST_IDLE_SLOT_ZERO: assert property (@(posedge out_clk) disable iff (!out_rst_n)
        !out_valid |-> (out_data == '0)); // R4

    AST_SOP_ONLY_WITH_BYTE: assert property (@(posedge out_clk) disable iff (!out_rst_n)
        out_sop |-> out_valid); // R5

    AST_FILL_BOUNDED: assert property (@(posedge in_clk) disable iff (!in_rst_n)
        fill_level <= PTR_W'(DEPTH)); // R7

    AST_OVERRUN_STICKY: assert property (@(posedge in_clk) disable iff (!in_rst_n)
        (overrun && !in_flag_clr) |=> overrun); // R8

    AST_UNDERRUN_STICKY: assert property (@(posedge out_clk) disable iff (!out_rst_n)
        (underrun && !out_flag_clr) |=> underrun); // R9

    AST_UNDERRUN_NO_BYTE: assert property (@(posedge out_clk) disable iff (!out_rst_n)
        $rose(underrun) |-> !out_valid); // R9

    AST_OVERRUN_CLEARS: assert property (@(posedge in_clk) disable iff (!in_rst_n)
        in_flag_clr |=> !overrun); // R10

    AST_UNDERRUN_CLEARS: assert property (@(posedge out_clk) disable iff (!out_rst_n)
        out_flag_clr |=> !underrun); // R10
endmodule

bind pkt_gap_buffer pgb_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
    .in_clk(in_clk), .in_rst_n(in_rst_n), .in_flag_clr(in_flag_clr),
    .fill_level(fill_level), .overrun(overrun), .out_clk(out_clk),
    .out_rst_n(out_rst_n), .out_flag_clr(out_flag_clr), .out_valid(out_valid),
    .out_data(out_data), .out_sop(out_sop), .underrun(underrun)
);

// File: tb/pkt_gap_buffer_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues every byte that should come out,
// and a monitor on the output clock checks order, strobes and gaps.
module pkt_gap_buffer_test;
    localparam int PKT = 188;
    localparam int GAP = 16;

    logic       in_clk = 1'b0;
    logic       out_clk = 1'b0;
    logic       in_rst_n = 1'b0;
    logic       out_rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_flag_clr = 1'b0;
    logic       out_flag_clr = 1'b0;
    logic [7:0] fill_level;
    logic       overrun;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_sop;
    logic       underrun;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    int  mon_idx = 0;
    bit  gap_pending = 0;
    int  gap_cnt = 0;

    always #2.0 in_clk = ~in_clk;   // 250 MHz input byte clock
    always #2.1 out_clk = ~out_clk; // slightly slower output slot clock

    pkt_gap_buffer uut (
        .in_clk(in_clk), .in_rst_n(in_rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_flag_clr(in_flag_clr), .fill_level(fill_level), .overrun(overrun),
        .out_clk(out_clk), .out_rst_n(out_rst_n), .out_flag_clr(out_flag_clr),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
        .underrun(underrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge in_clk);
        in_valid = 1'b1;
        in_data  = b;
    endtask

    task automatic idle_in(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge in_clk);
            in_valid = 1'b0;
            in_data  = 8'h00;
        end
    endtask

    function automatic logic [7:0] pkt_byte(input int seed, input int i);
        return (i == 0) ? 8'h47 : 8'((seed * 37 + i * 5 + 3) & 8'hFF);
    endfunction

    // Driver: send bytes [from, to) of a packet and queue them as expected.
    task automatic send_part(input int seed, input int from, input int to);
        for (int i = from; i < to; i++) begin
            send_byte(pkt_byte(seed, i));
            exp_q.push_back(pkt_byte(seed, i));
        end
    endtask

    // Monitor: compare each output byte and the framing around it.
    always @(negedge out_clk) begin
        if (out_rst_n) begin
            if (out_valid) begin
                if (gap_pending) begin
                    check(gap_cnt == GAP, "R4 parity gap length", gap_cnt, GAP);
                    gap_pending = 0;
                end
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected output byte", out_data, -1);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(out_data == e, "R3 byte order", out_data, e);
                end
                check(out_sop == (mon_idx % PKT == 0), "R5 sop strobe", out_sop, (mon_idx % PKT == 0));
                mon_idx++;
                if (mon_idx % PKT == 0) begin
                    gap_pending = 1;
                    gap_cnt = 0;
                end
            end else begin
                check(out_data == 8'h00 && !out_sop, "R4 idle slot zero", out_data, 0);
                if (gap_pending) gap_cnt++;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge in_clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int gaps[8] = '{0, 40, 10, 50, 26, 30, 5, 47};

        // R1: reset state
        repeat (6) @(negedge in_clk);
        in_rst_n = 1'b1;
        @(negedge out_clk);
        out_rst_n = 1'b1;
        @(negedge out_clk);
        check(!out_valid && !out_sop && out_data == 0, "R1 output idle after reset", out_valid, 0);
        check(underrun == 1'b0, "R1 underrun clear after reset", underrun, 0);
        @(negedge in_clk);
        check(fill_level == 0, "R1 fill zero after reset", fill_level, 0);
        check(overrun == 1'b0, "R1 overrun clear after reset", overrun, 0);

        // R2: bytes before a sync byte are hunted away (not queued)
        send_byte(8'h00);
        send_byte(8'h12);
        send_byte(8'hFF);
        send_byte(8'h46);

        // R6/R7: part of a packet, then a pause below the start threshold
        send_part(0, 0, 60);
        idle_in(30);
        check(fill_level == 60, "R2 R7 fill counts only accepted bytes", fill_level, 60);
        for (int i = 0; i < 20; i++) begin
            @(negedge out_clk);
            check(!out_valid, "R6 no output below threshold", out_valid, 0);
        end
        send_part(0, 60, PKT);

        // R3: packets with a range of gaps, zero included
        for (int p = 1; p < 8; p++) begin
            idle_in(gaps[p - 1]);
            send_part(p, 0, PKT);
        end
        idle_in(1);

        // Drain, then the next payload slot starves
        wait (exp_q.size() == 0);
        repeat (300) @(negedge out_clk);
        check(mon_idx == 8 * PKT, "R3 all bytes delivered", mon_idx, 8 * PKT);
        check(underrun == 1'b1, "R9 underrun after input stops", underrun, 1);
        check(!out_valid, "R9 no byte while starved", out_valid, 0);
        @(negedge in_clk);
        check(overrun == 1'b0, "R8 no overrun under bounded drift", overrun, 0);
        @(negedge out_clk);
        out_flag_clr = 1'b1;
        @(negedge out_clk);
        out_flag_clr = 1'b0;
        repeat (20) @(negedge out_clk);
        check(underrun == 1'b0, "R10 underrun cleared and stays clear", underrun, 0);

        // Overrun with the output side held in reset
        out_rst_n = 1'b0;
        in_rst_n  = 1'b0;
        repeat (6) @(negedge in_clk);
        exp_q.delete();
        mon_idx = 0;
        gap_pending = 0;
        in_rst_n = 1'b1;
        for (int i = 0; i < 130; i++) begin
            send_byte((i == 0) ? 8'h47 : 8'(i));
            if (i < 128) exp_q.push_back((i == 0) ? 8'h47 : 8'(i));
        end
        idle_in(4);
        check(fill_level == 128, "R7 fill at capacity", fill_level, 128);
        check(overrun == 1'b1, "R8 overrun on write to full store", overrun, 1);
        @(negedge in_clk);
        in_flag_clr = 1'b1;
        @(negedge in_clk);
        in_flag_clr = 1'b0;
        check(overrun == 1'b0, "R10 overrun cleared", overrun, 0);
        check(fill_level == 128, "R8 dropped bytes not stored", fill_level, 128);

        // Release output: 128 bytes out, then starve mid-packet
        @(negedge out_clk);
        out_rst_n = 1'b1;
        wait (exp_q.size() == 0);
        repeat (300) @(negedge out_clk);
        check(mon_idx == 128, "R8 only stored bytes delivered", mon_idx, 128);
        check(underrun == 1'b1, "R9 underrun mid packet", underrun, 1);
        check(!out_valid, "R9 output idle after underrun", out_valid, 0);
        @(negedge out_clk);
        out_flag_clr = 1'b1;
        @(negedge out_clk);
        out_flag_clr = 1'b0;
        @(negedge out_clk);
        check(underrun == 1'b0, "R10 underrun cleared", underrun, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule